// File: doc/BRIEF.md
# Instruction Byte-Stream Aligning Queue

This block sits between instruction fetch and decode. Each cycle fetch may hand it a 48-byte block together with the block's base address, a starting byte offset and a mode flag. The block cuts those bytes into whole instructions and appends them, oldest first, to a 40-entry circular queue. In fixed mode every instruction is 32 bits long. In compressed mode instructions are 16 or 32 bits long and may start at any halfword. A 32-bit instruction whose first halfword is the last halfword of a block is held back and joined with the next block.

Decode sees the six oldest queued instructions at once and reports how many it consumed. A block is taken whole or not at all: if the free entries cannot hold everything the block produces, `fetch_accept` stays low and fetch must present the same block again. When the queue ends a cycle full, `fetch_gate` rises for one cycle. A flush empties the queue and the held halfword at once.

Top module: `ibq_align`

## Requirements
- R1: In fixed mode (`fetch_cmode`=0), every 4-byte word at or above the starting offset rounded down to a multiple of 4 becomes one 32-bit entry. Its word is the block bytes little-endian, so the lower halfword comes from the lower address, and its PC is `fetch_pc` plus the word's byte index.
- R2: In compressed mode, a first halfword whose bits [15:11] equal 5'b11101, 5'b11110 or 5'b11111 starts a 32-bit instruction. The word is {next halfword, first halfword}. Any other first halfword is a complete 16-bit instruction.
- R3: In compressed mode, a 32-bit start in halfword 23 (the last one) yields no entry in that block. It is held with PC `fetch_pc`+46 and joined, as the low half, with the first used halfword of the next accepted compressed block.
- R4: Bytes below the starting offset are ignored. In compressed mode the offset is rounded down to an even value.
- R5: Each entry holds a 32-bit word, a length flag (`dec_is32`=1 for 32-bit) and a PC. A 16-bit entry carries zeros in word bits [31:16].
- R6: Slot j of the decode outputs shows the (j+1)-th oldest entry, and `dec_valid` is set for slots 0 to min(occupancy,6)-1. `dec_take` removes that many of the oldest entries at the clock edge.
- R7: `fetch_accept` is high in the same cycle exactly when `fetch_valid` is high, `flush` and `fetch_gate` are low, and the block's instruction count is at most 40 minus the occupancy at the start of the cycle. A block that is not accepted changes neither the queue nor the held halfword.
- R8: `fetch_gate` goes high in the cycle after any cycle that ends with 40 entries, unless it was high in that cycle. It is never high for two cycles in a row.
- R9: `flush` empties the queue, drops the held halfword, clears `fetch_gate` and refuses the fetch block of that cycle.
- R10: An accepted fixed-mode block drops a held halfword.
- R11: After reset the queue is empty, nothing is held and `fetch_gate` is low.
- R12: Occupancy never exceeds 40 and entries leave in the order they entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Redirect: empty everything, drop this cycle's fetch |
| fetch_valid | input | 1 | A fetch block is presented |
| fetch_pc | input | 32 | Address of byte 0 of the block |
| fetch_off | input | 6 | First byte of the block to use |
| fetch_cmode | input | 1 | 1 = mixed 16/32-bit mode, 0 = fixed 32-bit |
| fetch_bytes | input | 384 | Block bytes, byte k at bits [8k+7:8k] |
| fetch_accept | output | 1 | The block is taken this cycle |
| fetch_gate | output | 1 | Fetch stall pulse after the queue filled |
| dec_take | input | 3 | Number of oldest entries decode consumes |
| dec_valid | output | 6 | Per-slot valid, slot 0 oldest |
| dec_word | output | 192 | Instruction words, slot j at [32j+31:32j] |
| dec_is32 | output | 6 | Per-slot 32-bit length flag |
| dec_pc | output | 192 | Per-slot PC, slot j at [32j+31:32j] |

## Verification
`fetch_accept` depends only on this cycle's inputs and the stored occupancy, so the bench checks it 1 ns after it drives the fetch inputs, before the rising edge. Entries from an accepted block, the result of `dec_take` and a flush all appear after one rising edge. `fetch_gate` follows one edge after the cycle in which the queue ended full. For these reasons the decode slots and `fetch_gate` are compared at the next falling edge against a queue model that the bench updates once per cycle, right after its accept prediction.

// File: rtl/ibq_align.sv
module ibq_align #(
  parameter int FETCH_BYTES = 48,
  parameter int DEPTH       = 40,
  parameter int DEC_W       = 6,
  parameter int PCW         = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               flush,
  input  logic                               fetch_valid,
  input  logic [PCW-1:0]                     fetch_pc,
  input  logic [$clog2(FETCH_BYTES)-1:0]     fetch_off,
  input  logic                               fetch_cmode,
  input  logic [FETCH_BYTES*8-1:0]           fetch_bytes,
  output logic                               fetch_accept,
  output logic                               fetch_gate,
  input  logic [$clog2(DEC_W+1)-1:0]         dec_take,
  output logic [DEC_W-1:0]                   dec_valid,
  output logic [DEC_W*32-1:0]                dec_word,
  output logic [DEC_W-1:0]                   dec_is32,
  output logic [DEC_W*PCW-1:0]               dec_pc
);
  localparam int HW = FETCH_BYTES / 2;
  localparam int NW = $clog2(HW + 1);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);

  logic [31:0]    q_word [DEPTH];
  logic           q_is32 [DEPTH];
  logic [PCW-1:0] q_pc   [DEPTH];

  logic [PW-1:0]  head_q, tail_q;
  logic [CW-1:0]  count_q, count_nxt;
  logic           carry_q, gate_q;
  logic [15:0]    carry_hw_q;
  logic [PCW-1:0] carry_pc_q;

  logic [31:0]    p_word [HW];
  logic           p_is32 [HW];
  logic [PCW-1:0] p_pc   [HW];
  logic [NW-1:0]  n_new;
  logic           c_v;
  logic [15:0]    c_hw;
  logic [PCW-1:0] c_pc;
  logic [PW-1:0]  wr_idx [HW];
  logic [PW-1:0]  rd_idx [DEC_W];
  int             pop_n;
  logic           acc;

  wire [FETCH_BYTES*8+15:0] bx = {16'h0, fetch_bytes};

  function automatic logic starts_long(input logic [15:0] h);
    return (h[15:13] == 3'b111) && (h[12:11] != 2'b00);
  endfunction

  function automatic logic [PW-1:0] wrap(input int v);
    return PW'((v >= DEPTH) ? v - DEPTH : v);
  endfunction

  always_comb begin
    int first;
    logic pend, skip;
    logic [15:0] hw, nx;
    n_new = '0;
    c_v   = 1'b0;
    c_hw  = '0;
    c_pc  = '0;
    pend  = carry_q & fetch_cmode;
    skip  = 1'b0;
    hw    = '0;
    nx    = '0;
    first = fetch_cmode ? int'(fetch_off >> 1) : int'(fetch_off >> 2) * 2;
    for (int i = 0; i < HW; i++) begin
      p_word[i] = '0;
      p_is32[i] = 1'b0;
      p_pc[i]   = '0;
    end
    for (int h = 0; h < HW; h++) begin
      hw = bx[16*h +: 16];
      nx = bx[16*h+16 +: 16];
      if (h >= first) begin
        if (!fetch_cmode) begin
          if (h % 2 == 0) begin
            p_word[n_new] = {nx, hw};
            p_is32[n_new] = 1'b1;
            p_pc[n_new]   = fetch_pc + PCW'(2*h);
            n_new         = n_new + 1'b1;
          end
        end else if (skip) begin
          skip = 1'b0;
        end else if (pend) begin
          p_word[n_new] = {hw, carry_hw_q};
          p_is32[n_new] = 1'b1;
          p_pc[n_new]   = carry_pc_q;
          n_new         = n_new + 1'b1;
          pend          = 1'b0;
        end else if (starts_long(hw)) begin
          if (h == HW - 1) begin
            c_v  = 1'b1;
            c_hw = hw;
            c_pc = fetch_pc + PCW'(2*h);
          end else begin
            p_word[n_new] = {nx, hw};
            p_is32[n_new] = 1'b1;
            p_pc[n_new]   = fetch_pc + PCW'(2*h);
            n_new         = n_new + 1'b1;
            skip          = 1'b1;
          end
        end else begin
          p_word[n_new] = {16'h0, hw};
          p_is32[n_new] = 1'b0;
          p_pc[n_new]   = fetch_pc + PCW'(2*h);
          n_new         = n_new + 1'b1;
        end
      end
    end
  end

  always_comb begin
    int avail;
    avail = (int'(count_q) > DEC_W) ? DEC_W : int'(count_q);
    pop_n = (int'(dec_take) > avail) ? avail : int'(dec_take);
    for (int i = 0; i < HW; i++) wr_idx[i] = wrap(int'(tail_q) + i);
    for (int j = 0; j < DEC_W; j++) rd_idx[j] = wrap(int'(head_q) + j);
  end

  assign acc = fetch_valid && !flush && !gate_q &&
               (int'(n_new) <= DEPTH - int'(count_q));
  assign count_nxt = CW'(int'(count_q) - pop_n + (acc ? int'(n_new) : 0));
  assign fetch_accept = acc;
  assign fetch_gate   = gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q     <= '0;
      tail_q     <= '0;
      count_q    <= '0;
      carry_q    <= 1'b0;
      carry_hw_q <= '0;
      carry_pc_q <= '0;
      gate_q     <= 1'b0;
    end else if (flush) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      carry_q <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      head_q  <= wrap(int'(head_q) + pop_n);
      count_q <= count_nxt;
      gate_q  <= !gate_q && (int'(count_nxt) == DEPTH);
      if (acc) begin
        tail_q     <= wrap(int'(tail_q) + int'(n_new));
        carry_q    <= c_v;
        carry_hw_q <= c_hw;
        carry_pc_q <= c_pc;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < HW; i++) begin
      if (acc && (i < int'(n_new))) begin
        q_word[wr_idx[i]] <= p_word[i];
        q_is32[wr_idx[i]] <= p_is32[i];
        q_pc[wr_idx[i]]   <= p_pc[i];
      end
    end
  end

  for (genvar j = 0; j < DEC_W; j++) begin : g_slot
    assign dec_valid[j]            = int'(count_q) > j;
    assign dec_word[32*j +: 32]    = q_word[rd_idx[j]];
    assign dec_is32[j]             = q_is32[rd_idx[j]];
    assign dec_pc[PCW*j +: PCW]    = q_pc[rd_idx[j]];
  end
endmodule

// File: rtl/ibq_align_chk.sv
module ibq_align_chk #(
  parameter int DEPTH = 40,
  parameter int DEC_W = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       flush,
  input logic                       fetch_accept,
  input logic                       fetch_gate,
  input logic [DEC_W-1:0]           dec_valid,
  input logic [$clog2(DEPTH+1)-1:0] count
);
  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  a_r8_gate_single: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_gate |=> !fetch_gate);

  a_r7_gate_blocks_accept: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_gate |-> !fetch_accept);

  a_r9_flush_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !fetch_accept);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (dec_valid == '0 && !fetch_gate));

  a_r6_slots_packed: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid & (dec_valid + 1'b1)) == '0);
endmodule

bind ibq_align ibq_align_chk #(.DEPTH(DEPTH), .DEC_W(DEC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .fetch_accept (fetch_accept),
  .fetch_gate   (fetch_gate),
  .dec_valid    (dec_valid),
  .count        (count_q)
);

// File: tb/sim_ibq_align.sv
`timescale 1ns/1ps
module sim_ibq_align;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush = 1'b0;
  logic         fetch_valid = 1'b0;
  logic [31:0]  fetch_pc = '0;
  logic [5:0]   fetch_off = '0;
  logic         fetch_cmode = 1'b0;
  logic [383:0] fetch_bytes = '0;
  logic         fetch_accept, fetch_gate;
  logic [2:0]   dec_take = '0;
  logic [5:0]   dec_valid, dec_is32;
  logic [191:0] dec_word, dec_pc;

  always #4 clk = ~clk;

  ibq_align u0 (.*);

  int nchk = 0, nfail = 0;
  logic [31:0] mw[$], mp[$];
  bit          ml[$];
  logic [31:0] tw[$], tp[$];
  bit          tl[$];
  bit          m_cv = 0, m_gate = 0;
  logic [15:0] m_chw = '0;
  logic [31:0] m_cpc = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_long(input logic [15:0] h);
    return h[15:11] == 5'b11101 || h[15:11] == 5'b11110 || h[15:11] == 5'b11111;
  endfunction

  // parse per R1..R4, R10 into tw/tl/tp; carry in/out through the refs
  task automatic parse(input logic [383:0] d, input logic [31:0] base, input int off, input bit cm,
                       ref bit cv, ref logic [15:0] chw, ref logic [31:0] cpc);
    int pos;
    logic [15:0] a, b;
    tw.delete(); tl.delete(); tp.delete();
    if (!cm) cv = 0;
    pos = cm ? off / 2 : (off / 4) * 2;
    while (pos < 24) begin
      a = d[16*pos +: 16];
      b = (pos < 23) ? d[16*pos+16 +: 16] : 16'h0;
      if (!cm) begin
        tw.push_back({b, a}); tl.push_back(1); tp.push_back(base + 32'(2*pos)); pos += 2;
      end else if (cv) begin
        tw.push_back({a, chw}); tl.push_back(1); tp.push_back(cpc); cv = 0; pos += 1;
      end else if (is_long(a)) begin
        if (pos == 23) begin cv = 1; chw = a; cpc = base + 32'd46; pos += 1; end
        else begin tw.push_back({b, a}); tl.push_back(1); tp.push_back(base + 32'(2*pos)); pos += 2; end
      end else begin
        tw.push_back({16'h0, a}); tl.push_back(0); tp.push_back(base + 32'(2*pos)); pos += 1;
      end
    end
  endtask

  task automatic cyc(input bit fv, input bit fl, input int off, input bit cm,
                     input logic [383:0] d, input logic [31:0] pc, input int take);
    int lim;
    bit cv; logic [15:0] chw; logic [31:0] cpc;
    bit ea;
    @(negedge clk);
    for (int j = 0; j < 6; j++) begin
      bit ev;
      ev = j < mw.size();
      chk(dec_valid[j] == ev, "R6 slot valid", 32'(dec_valid[j]), 32'(ev));
      if (ev) begin
        chk(dec_word[32*j +: 32] == mw[j], "R1 R2 R3 R4 R5 R10 word", dec_word[32*j +: 32], mw[j]);
        chk(dec_is32[j] == ml[j], "R5 length flag", 32'(dec_is32[j]), 32'(ml[j]));
        chk(dec_pc[32*j +: 32] == mp[j], "R1 R5 R12 pc order", dec_pc[32*j +: 32], mp[j]);
      end
    end
    chk(fetch_gate == m_gate, "R8 gate", 32'(fetch_gate), 32'(m_gate));
    lim = mw.size() < 6 ? mw.size() : 6;
    if (take > lim) take = lim;
    fetch_valid = fv; flush = fl; fetch_off = 6'(off); fetch_cmode = cm;
    fetch_bytes = d; fetch_pc = pc; dec_take = 3'(take);
    #1;
    cv = m_cv; chw = m_chw; cpc = m_cpc;
    parse(d, pc, off, cm, cv, chw, cpc);
    ea = fv && !fl && !m_gate && (tw.size() <= 40 - mw.size());
    chk(fetch_accept == ea, "R7 R9 accept", 32'(fetch_accept), 32'(ea));
    if (fl) begin
      mw.delete(); ml.delete(); mp.delete(); m_cv = 0; m_gate = 0;
    end else begin
      for (int k = 0; k < take; k++) begin void'(mw.pop_front()); void'(ml.pop_front()); void'(mp.pop_front()); end
      if (ea) begin
        foreach (tw[k]) begin mw.push_back(tw[k]); ml.push_back(tl[k]); mp.push_back(tp[k]); end
        m_cv = cv; m_chw = chw; m_cpc = cpc;
      end
      m_gate = !m_gate && (mw.size() == 40);
    end
  endtask

  function automatic logic [383:0] rblk(input bit cm);
    logic [383:0] d;
    logic [31:0] v;
    for (int h = 0; h < 24; h++) begin
      v = $urandom;
      if (cm && ($urandom % 3 == 0)) v[15:11] = 5'b11101 + 5'($urandom % 3);
      d[16*h +: 16] = v[15:0];
    end
    return d;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [383:0] d;
    void'($urandom(32'h1b0a));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: empty, no gate, no accept after reset
    chk(dec_valid == 0, "R11 reset valid", 32'(dec_valid), 0);
    chk(fetch_gate == 0, "R11 reset gate", 32'(fetch_gate), 0);
    chk(fetch_accept == 0, "R11 reset accept", 32'(fetch_accept), 0);

    // R1: fixed block, offset 0 and offset 6 (R4 rounds down to 4)
    cyc(1, 0, 0, 0, rblk(0), 32'h1000, 0);
    cyc(1, 0, 6, 0, rblk(0), 32'h2000, 6);
    // R2 R4: compressed, odd offset
    cyc(1, 0, 13, 1, rblk(1), 32'h3000, 6);
    // R3: long start in last halfword, joined into next block at offset 10
    d = rblk(1); d[383:368] = 16'hF123;
    cyc(1, 0, 0, 1, d, 32'h4000, 6);
    cyc(1, 0, 10, 1, rblk(1), 32'h5000, 6);
    // R10: held halfword then fixed block drops it
    d = rblk(1); d[383:368] = 16'hE800;
    cyc(1, 0, 40, 1, d, 32'h6000, 6);
    cyc(1, 0, 0, 0, rblk(0), 32'h7000, 6);
    cyc(1, 0, 0, 1, rblk(1), 32'h8000, 6);
    // R9: flush with a held halfword and data present
    d = rblk(1); d[383:368] = 16'hF800;
    cyc(1, 0, 0, 1, d, 32'h9000, 0);
    cyc(1, 1, 0, 1, rblk(1), 32'hA000, 0);
    cyc(1, 0, 0, 1, rblk(1), 32'hB000, 0);
    repeat (4) cyc(0, 0, 0, 0, '0, 0, 6);
    // R7 R8 R12: fill to exactly 40, gate pulse, rejected block
    repeat (3) cyc(1, 0, 0, 0, rblk(0), 32'hC000, 0);
    cyc(1, 0, 32, 0, rblk(0), 32'hD000, 0);
    repeat (4) cyc(1, 0, 0, 0, rblk(0), 32'hE000, 0);
    repeat (10) cyc(0, 0, 0, 0, '0, 0, 6);

    for (int n = 0; n < 6000; n++) begin
      bit cm;
      int take;
      cm = ($urandom % 4) != 0;
      take = ((n / 500) % 2 == 1) ? int'($urandom % 2) : int'($urandom % 7);
      cyc(($urandom % 8) != 0, ($urandom % 97) == 0, int'($urandom % 48), cm,
          rblk(cm), $urandom & 32'hFFFF_FFFE, take);
    end
    repeat (12) cyc(0, 0, 0, 0, '0, 0, 6);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule